// File: doc/BRIEF.md
# Single-Cycle Load/Store Datapath

This block is a small 32-bit processor core that completes one instruction per clock. It holds a program counter, a word-wide instruction store, a 32-entry register file with two combinational read ports and one clocked write port, an ALU steered by a 3-bit operation code, a sign extender for the 16-bit displacement, a word-wide data store, and a decoder that derives every control line from the instruction word. Only three instruction classes run: register-to-register arithmetic and logic, word load, and word store.

Both stores are filled through a load port while reset is held. After reset is released, the program counter steps through the program and each instruction's effects are visible on the observation ports in the same cycle: the register write bus, the data-store access bus and the read strobe. Register and store updates land on the next rising edge, so the following instruction already sees them.

Top module: `sc_datapath`

## Requirements
- R1: While reset is held, pc_o is 0. After release, pc_o rises by exactly 4 on every clock edge, and the executing instruction is the instruction-store word at index pc_o[7:2].
- R2: An instruction with opcode bits [31:26] = 0x00 uses funct bits [5:0]: 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 is bitwise AND and 0x25 is bitwise OR. rs is bits [25:21] and rt is bits [20:16]. The result appears on rf_wdata_o with rf_we_o = 1 and rf_waddr_o = rd (bits [15:11]), and dm_we_o = dm_re_o = 0.
- R3: Funct 0x2A writes 1 when rs is less than rt as signed 32-bit values and 0 otherwise, including when the operands are equal.
- R4: Opcode 0x23 (load word) drives dm_addr_o = rs + sign-extended bits [15:0] and asserts dm_re_o. It writes the addressed data word to register rt (bits [20:16]) with rf_we_o = 1 and dm_we_o = 0.
- R5: Opcode 0x2B (store word) drives dm_we_o = 1, dm_addr_o = rs + sign-extended displacement and dm_wdata_o = register rt, with rf_we_o = 0 and dm_re_o = 0. A later load from that address returns the stored word.
- R6: The displacement is sign extended: a value with bit 15 set subtracts from the base register.
- R7: Register 0 always reads as zero. A write that targets register 0 leaves it at zero.
- R8: Any other opcode, and any opcode-0x00 funct not listed in R2 or R3, asserts none of rf_we_o, dm_we_o or dm_re_o and changes no register.
- R9: A register written by one instruction holds the new value as a source operand of the very next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_imem_we | input | 1 | Write ld_data into the instruction store at ld_addr |
| ld_dmem_we | input | 1 | Write ld_data into the data store at ld_addr |
| ld_addr | input | 6 | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| rf_we_o | output | 1 | Register write enable from the decoder |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value to be written back |
| dm_we_o | output | 1 | Data-store write strobe |
| dm_re_o | output | 1 | Data-store read strobe |
| dm_addr_o | output | 32 | Data-store byte address from the ALU |
| dm_wdata_o | output | 32 | Data to be stored |

## Verification
On every cycle the assertions check that the program counter steps by four, that register 0 holds zero, that a store never coincides with a register write, and that a load always routes memory data to the rt field. Whether each arithmetic result, signed comparison, effective address and loaded word is actually correct can only be shown by the bench's scenarios, which compare every instruction against a model kept from the requirements, including stores followed by loads, writes to register 0, unsupported encodings and back-to-back dependent instructions.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_ALU   = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // bit 2: invert B and carry in one; bits 1:0: result select
    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    mem_write;
        logic    mem_read;
        logic    dst_rt;
        logic    b_imm;
        logic    wb_mem;
        alu_op_e alu_op;
    } ctl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl
);

    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        case (opcode)
            OPC_ALU: begin
                ctl.reg_write = 1'b1;
                case (funct)
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    default: ctl.reg_write = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                ctl.reg_write = 1'b1;
                ctl.mem_read  = 1'b1;
                ctl.dst_rt    = 1'b1;
                ctl.b_imm     = 1'b1;
                ctl.wb_mem    = 1'b1;
            end
            OPC_STORE: begin
                ctl.mem_write = 1'b1;
                ctl.b_imm     = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    // R4: a load must write the rt register with memory data
    p_load_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_read |-> (ctl.reg_write && ctl.dst_rt && ctl.wb_mem && ctl.alu_op == ALU_ADD));

    // R8: strobes only for the three supported classes
    p_unsupported_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OPC_ALU && opcode != OPC_LOAD && opcode != OPC_STORE)
            |-> !(ctl.reg_write || ctl.mem_write || ctl.mem_read));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    logic         negate;
    logic [1:0]   sel;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         less;

    always_comb begin
        negate = op[2];
        sel    = op[1:0];
        b_eff  = negate ? ~b : b;
        sum    = a + b_eff + {{(W-1){1'b0}}, negate};
        less   = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];
        case (sel)
            2'b00:   y = a & b_eff;
            2'b01:   y = a | b_eff;
            2'b10:   y = sum;
            default: y = {{(W-1){1'b0}}, less};
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] ra1,
    input  logic [$clog2(NREG)-1:0] ra2,
    output logic [W-1:0]            rd1,
    output logic [W-1:0]            rd2,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [W-1:0]            wd
);

    logic [W-1:0] rf_d [NREG];
    logic [W-1:0] rf_q [NREG];

    always_comb begin
        rf_d = rf_q;
        if (we && wa != '0) begin
            rf_d[wa] = wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                rf_q[i] <= '0;
            end
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : rf_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : rf_q[ra2];

    // R7: the stored zero register never changes
    p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q[0] == '0);

endmodule

// File: rtl/sc_wmem.sv
module sc_wmem #(
    parameter int W     = 32,
    parameter int WORDS = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(WORDS)-1:0] raddr,
    output logic [W-1:0]             rdata
);

    logic [W-1:0] mem_d [WORDS];
    logic [W-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
    import sc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int NREG       = 32
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              ld_imem_we,
    input  logic                                              ld_dmem_we,
    input  logic [$clog2((IMEM_WORDS > DMEM_WORDS) ? IMEM_WORDS : DMEM_WORDS)-1:0] ld_addr,
    input  logic [XLEN-1:0]                                   ld_data,
    output logic [XLEN-1:0]                                   pc_o,
    output logic [31:0]                                       instr_o,
    output logic                                              rf_we_o,
    output logic [4:0]                                        rf_waddr_o,
    output logic [XLEN-1:0]                                   rf_wdata_o,
    output logic                                              dm_we_o,
    output logic                                              dm_re_o,
    output logic [XLEN-1:0]                                   dm_addr_o,
    output logic [XLEN-1:0]                                   dm_wdata_o
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t state_d, state_q;

    logic [31:0]     instr;
    ctl_t            ctl;
    logic [4:0]      rs, rt, rd, waddr;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y;
    logic [XLEN-1:0] dm_rdata, wb_val;
    logic            dmem_we;
    logic [DAW-1:0]  dmem_waddr;

    // dedicated incrementer: no enable, no operation select
    always_comb begin
        state_d    = state_q;
        state_d.pc = state_q.pc + XLEN'(4);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    sc_wmem #(.W(32), .WORDS(IMEM_WORDS)) u_imem (
        .clk   (clk),
        .we    (ld_imem_we),
        .waddr (ld_addr[IAW-1:0]),
        .wdata (ld_data[31:0]),
        .raddr (state_q.pc[IAW+1:2]),
        .rdata (instr)
    );

    assign rs = instr[25:21];
    assign rt = instr[20:16];
    assign rd = instr[15:11];

    sc_decoder u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    always_comb begin
        imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
        waddr   = ctl.dst_rt ? rt : rd;
        alu_b   = ctl.b_imm ? imm_ext : rt_val;
        wb_val  = ctl.wb_mem ? dm_rdata : alu_y;
    end

    sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (rs),
        .ra2   (rt),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (ctl.reg_write),
        .wa    (waddr),
        .wd    (wb_val)
    );

    sc_alu #(.W(XLEN)) u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctl.alu_op),
        .y  (alu_y)
    );

    // load port has priority; program stores are held off during reset
    always_comb begin
        dmem_we    = ld_dmem_we | (ctl.mem_write & rst_n);
        dmem_waddr = ld_dmem_we ? ld_addr[DAW-1:0] : alu_y[DAW+1:2];
    end

    sc_wmem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (ld_dmem_we ? ld_data : rt_val),
        .raddr (alu_y[DAW+1:2]),
        .rdata (dm_rdata)
    );

    assign pc_o       = state_q.pc;
    assign instr_o    = instr;
    assign rf_we_o    = ctl.reg_write;
    assign rf_waddr_o = waddr;
    assign rf_wdata_o = wb_val;
    assign dm_we_o    = ctl.mem_write;
    assign dm_re_o    = ctl.mem_read;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    logic unused_bits;
    assign unused_bits = ^{state_q.pc[1:0], state_q.pc[XLEN-1:IAW+2],
                           alu_y[1:0], alu_y[XLEN-1:DAW+2], instr[10:6]};

    // R1: the counter moves by one word per cycle
    p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (state_q.pc == $past(state_q.pc) + XLEN'(4)));

    // R5: a store never also writes a register
    p_store_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> (!rf_we_o && !dm_re_o));

endmodule

// File: tb/sc_datapath_bench.sv
module sc_datapath_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IWORDS     = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_imem_we = 1'b0;
    logic        ld_dmem_we = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic        rf_we_o, dm_we_o, dm_re_o;
    logic [4:0]  rf_waddr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_datapath u_sc_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_imem_we (ld_imem_we),
        .ld_dmem_we (ld_dmem_we),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .pc_o       (pc_o),
        .instr_o    (instr_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_re_o    (dm_re_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    typedef struct {
        int          idx;
        logic        rf_we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        dm_we;
        logic        dm_re;
        logic [31:0] addr;
        logic [31:0] sd;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_rf [32];
    logic [31:0] m_mem [64];
    int          pcount = 0;

    function automatic logic [31:0] sext(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic put_instr(input logic [31:0] w);
        @(negedge clk);
        ld_imem_we = 1'b1;
        ld_dmem_we = 1'b0;
        ld_addr    = 6'(pcount);
        ld_data    = w;
        pcount++;
    endtask

    task automatic put_data(input int idx, input logic [31:0] v);
        @(negedge clk);
        ld_dmem_we = 1'b1;
        ld_imem_we = 1'b0;
        ld_addr    = 6'(idx);
        ld_data    = v;
        m_mem[idx] = v;
    endtask

    function automatic exp_t blank(input string tag);
        exp_t e;
        e.idx = pcount; e.rf_we = 1'b0; e.wa = '0; e.wd = '0;
        e.dm_we = 1'b0; e.dm_re = 1'b0; e.addr = '0; e.sd = '0; e.tag = tag;
        return e;
    endfunction

    task automatic emit_r(input logic [5:0] fn, input logic [4:0] rs, input logic [4:0] rt,
                          input logic [4:0] rd, input string tag);
        exp_t e = blank(tag);
        logic [31:0] a = m_rf[rs];
        logic [31:0] b = m_rf[rt];
        logic [31:0] y;
        case (fn)
            6'h20:   y = a + b;
            6'h22:   y = a - b;
            6'h24:   y = a & b;
            6'h25:   y = a | b;
            default: y = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
        e.rf_we = 1'b1; e.wa = rd; e.wd = y;
        if (rd != 0) m_rf[rd] = y;
        sb.push_back(e);
        put_instr({6'h00, rs, rt, rd, 5'h00, fn});
    endtask

    task automatic emit_lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                           input string tag);
        exp_t e = blank(tag);
        logic [31:0] ad = m_rf[rs] + sext(imm);
        e.rf_we = 1'b1; e.wa = rt; e.wd = m_mem[ad[7:2]];
        e.dm_re = 1'b1; e.addr = ad;
        if (rt != 0) m_rf[rt] = m_mem[ad[7:2]];
        sb.push_back(e);
        put_instr({6'h23, rs, rt, imm});
    endtask

    task automatic emit_sw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                           input string tag);
        exp_t e = blank(tag);
        logic [31:0] ad = m_rf[rs] + sext(imm);
        e.dm_we = 1'b1; e.addr = ad; e.sd = m_rf[rt];
        m_mem[ad[7:2]] = m_rf[rt];
        sb.push_back(e);
        put_instr({6'h2B, rs, rt, imm});
    endtask

    task automatic emit_quiet(input logic [31:0] w, input string tag);
        sb.push_back(blank(tag));
        put_instr(w);
    endtask

    task automatic check_item(input exp_t e);
        bit ok = 1'b1;
        checks++;
        if (pc_o != 32'(e.idx * 4)) ok = 1'b0;
        if (rf_we_o !== e.rf_we || dm_we_o !== e.dm_we || dm_re_o !== e.dm_re) ok = 1'b0;
        if (e.rf_we && (rf_waddr_o !== e.wa || rf_wdata_o !== e.wd)) ok = 1'b0;
        if ((e.dm_we || e.dm_re) && dm_addr_o !== e.addr) ok = 1'b0;
        if (e.dm_we && dm_wdata_o !== e.sd) ok = 1'b0;
        if (!ok) begin
            errors++;
            $display("FAIL %s (R1 pc) #%0d: pc=%h/%h rf_we=%b/%b wa=%0d/%0d wd=%h/%h dm_we=%b/%b dm_re=%b/%b addr=%h/%h sd=%h/%h",
                     e.tag, e.idx, pc_o, 32'(e.idx * 4), rf_we_o, e.rf_we, rf_waddr_o, e.wa,
                     rf_wdata_o, e.wd, dm_we_o, e.dm_we, dm_re_o, e.dm_re, dm_addr_o, e.addr,
                     dm_wdata_o, e.sd);
        end
    endtask

    // monitor: pops one expected item per executed instruction
    initial begin
        @(posedge rst_n);
        while (sb.size() > 0) begin
            exp_t e;
            #(CLK_PERIOD/4);
            e = sb.pop_front();
            check_item(e);
            @(negedge clk);
        end
        done = 1'b1;
    end

    // driver
    initial begin
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        repeat (2) @(negedge clk);
        checks++;
        if (pc_o !== 32'd0) begin
            errors++;
            $display("FAIL R1 reset pc: actual %h expected %h", pc_o, 32'd0);
        end
        put_data(1, 32'd7);
        put_data(2, 32'hFFFF_FFFD);
        put_data(3, 32'h1234_5678);
        put_data(10, 32'd64);
        for (int i = 11; i < 64; i++) put_data(i, 32'h0);
        put_data(0, 32'h0);
        put_data(4, 32'h0);
        put_data(5, 32'h0);
        put_data(6, 32'h0);
        put_data(7, 32'h0);
        put_data(8, 32'h0);
        put_data(9, 32'h0);
        emit_lw(5'd1, 5'd0, 16'd4,  "R4 lw r1");
        emit_lw(5'd2, 5'd0, 16'd8,  "R4 lw r2 negative");
        emit_lw(5'd3, 5'd0, 16'd12, "R4 lw r3");
        emit_lw(5'd4, 5'd0, 16'd40, "R4 lw r4 base");
        emit_r(6'h20, 5'd1, 5'd2, 5'd5,  "R2 add");
        emit_r(6'h22, 5'd1, 5'd2, 5'd6,  "R2 sub");
        emit_r(6'h24, 5'd3, 5'd2, 5'd7,  "R2 and");
        emit_r(6'h25, 5'd1, 5'd3, 5'd8,  "R2 or");
        emit_r(6'h2A, 5'd2, 5'd1, 5'd9,  "R3 slt neg<pos");
        emit_r(6'h2A, 5'd1, 5'd2, 5'd10, "R3 slt pos<neg");
        emit_r(6'h2A, 5'd1, 5'd1, 5'd11, "R3 slt equal");
        emit_sw(5'd5, 5'd4, 16'hFFF8, "R5 R6 sw negative disp");
        emit_lw(5'd12, 5'd4, 16'hFFF8, "R5 R6 lw after sw");
        emit_sw(5'd3, 5'd4, 16'd0, "R5 sw base");
        emit_lw(5'd13, 5'd0, 16'd64, "R5 lw back");
        emit_r(6'h20, 5'd1, 5'd1, 5'd0, "R7 write r0");
        emit_r(6'h20, 5'd0, 5'd1, 5'd14, "R7 read r0");
        emit_sw(5'd0, 5'd0, 16'd20, "R7 store r0");
        emit_quiet({6'h08, 5'd1, 5'd14, 16'h0001}, "R8 bad opcode");
        emit_quiet({6'h00, 5'd1, 5'd1, 5'd14, 5'd0, 6'h00}, "R8 bad funct");
        emit_sw(5'd14, 5'd0, 16'd24, "R8 r14 unchanged");
        emit_r(6'h20, 5'd5, 5'd6, 5'd15, "R9 producer");
        emit_r(6'h20, 5'd15, 5'd15, 5'd16, "R9 consumer");
        emit_sw(5'd16, 5'd0, 16'd28, "R9 result out");
        while (pcount < IWORDS) emit_quiet(32'h0, "R8 trailing nop");
        @(negedge clk);
        ld_imem_we = 1'b0;
        ld_dmem_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wait (done);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule